// File: doc/BRIEF.md
# Transmit-Context Interrupt Event Register with Set/Clear Aliases

This block collects completion interrupts from eight isochronous transmit DMA contexts into one memory-mapped event register. A context's event bit latches on a low-to-high transition of that context's interrupt line. Software may also force a bit on by writing a one through a set alias. A bit goes off only when software writes a one to that bit through a separate clear alias. Writing zeros through either alias changes nothing.

An eight-bit enable mask has its own set and clear aliases. The register drives one summary interrupt, which is high whenever any enabled event is pending. That output is meant to feed a single bit of a chip-level interrupt event register. Software that sees the summary reads the clear alias to learn which enabled contexts are waiting. Reading the set alias shows every latched event, whether or not it is enabled.

The bus port is a simple synchronous register port. Read data appears one cycle after the read strobe. The interrupt lines are taken to be synchronous to the bus clock.

The event bits have no defined reset value. Software clears them before it relies on them.

Access decoding is named by an enumerated access kind: `ACC_NONE`, `ACC_EVT_SET`, `ACC_EVT_CLR`, `ACC_MSK_SET` and `ACC_MSK_CLR`. There is no sequential state beyond the event, mask, edge-history and read-data registers.

Top module: `iso_tx_evt_reg`

## Requirements
- R1: Read data bits 31 down to 8 are always zero, and write data bits 31 down to 8 have no effect.
- R2: A context's event bit is set in the cycle its `ctx_irq` line is sampled high after being sampled low. A line held high does not set the bit again after it is cleared.
- R3: Writing to offset 0x90 sets each event bit whose write-data bit is 1. Bits written 0 are unchanged.
- R4: Writing to offset 0x94 clears each event bit whose write-data bit is 1. Bits written 0 are unchanged. This is the only way an event bit becomes 0.
- R5: A read of offset 0x94 returns the event bits ANDed with the mask bits, in bits 7..0, where bit n is context n.
- R6: A read of offset 0x90 returns the raw event bits in bits 7..0.
- R7: If a rising edge and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: The mask resets to zero. Writing a 1 at offset 0x98 sets a mask bit, and writing a 1 at offset 0x9C clears it. A read of either offset returns the mask.
- R9: `irq_summary` is high exactly when some event bit and its mask bit are both 1. It follows register writes and edges in the cycle after the clock edge that updates them.
- R10: `bus_rdata` carries the data for a read one clock after the clock edge that samples `bus_rd`. It is zero after any edge without a read.
- R11: Reads of any other offset return zero, and writes to any other offset change neither events nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| ctx_irq | input | 8 | Per-context interrupt lines, edge-sensitive |
| irq_summary | output | 1 | OR of enabled pending events |

## Verification
The bench builds the block with its defaults: eight contexts, an eight-bit offset bus and the four offsets 0x90 to 0x9C. With eight contexts, every lane of the edge, set and clear logic is driven through the bus. Bit 8 and above lie in the reserved range, so writing all ones tests that upper write data is ignored. The 8-bit offset also lets the bench hit an unmapped word just past the mask aliases. Timing-critical cases use single-cycle stimulus: a clear that collides with a new edge, and a clear while the line is still held high.

// File: rtl/iso_tx_evt_pkg.sv
package iso_tx_evt_pkg;
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_EVT_SET,
        ACC_EVT_CLR,
        ACC_MSK_SET,
        ACC_MSK_CLR
    } acc_e;
endpackage

// File: rtl/iso_evt_decode.sv
module iso_evt_decode
    import iso_tx_evt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFF_EVT_SET = 8'h90,
    parameter logic [ADDR_W-1:0] OFF_EVT_CLR = 8'h94,
    parameter logic [ADDR_W-1:0] OFF_MSK_SET = 8'h98,
    parameter logic [ADDR_W-1:0] OFF_MSK_CLR = 8'h9C
) (
    input  logic [ADDR_W-1:0] addr_i,
    output acc_e              kind_o
);
    always_comb begin
        if (addr_i == OFF_EVT_SET)      kind_o = ACC_EVT_SET;
        else if (addr_i == OFF_EVT_CLR) kind_o = ACC_EVT_CLR;
        else if (addr_i == OFF_MSK_SET) kind_o = ACC_MSK_SET;
        else if (addr_i == OFF_MSK_CLR) kind_o = ACC_MSK_CLR;
        else                            kind_o = ACC_NONE;
    end
endmodule

// File: rtl/iso_evt_edge.sv
module iso_evt_edge #(
    parameter int NCTX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCTX-1:0] irq_i,
    output logic [NCTX-1:0] rise_o
);
    logic [NCTX-1:0] prev_q;

    for (genvar g = 0; g < NCTX; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= irq_i[g];
        end
        assign rise_o[g] = irq_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/iso_evt_bits.sv
module iso_evt_bits #(
    parameter int NCTX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCTX-1:0] rise_i,
    input  logic [NCTX-1:0] evt_set_i,
    input  logic [NCTX-1:0] evt_clr_i,
    input  logic [NCTX-1:0] msk_set_i,
    input  logic [NCTX-1:0] msk_clr_i,
    output logic [NCTX-1:0] evt_o,
    output logic [NCTX-1:0] msk_o
);
    logic [NCTX-1:0] evt_q;
    logic [NCTX-1:0] msk_q;
    logic [NCTX-1:0] evt_d;
    logic [NCTX-1:0] msk_d;

    always_comb begin
        // set sources take priority over a clear in the same cycle
        evt_d = (evt_q & ~evt_clr_i) | rise_i | evt_set_i;
        msk_d = (msk_q & ~msk_clr_i) | msk_set_i;
    end

    // event bits have no defined reset value
    always_ff @(posedge clk) begin
        evt_q <= evt_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) msk_q <= '0;
        else        msk_q <= msk_d;
    end

    assign evt_o = evt_q;
    assign msk_o = msk_q;

    // R4
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_clr_i & ~rise_i & ~evt_set_i)) |=>
        ((evt_q & $past(evt_clr_i & ~rise_i & ~evt_set_i)) == '0));

    // R7
    rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_i) |=> ((evt_q & $past(rise_i)) == $past(rise_i)));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|msk_set_i || |msk_clr_i) |=> $stable(msk_q));
endmodule

// File: rtl/iso_tx_evt_reg.sv
module iso_tx_evt_reg
    import iso_tx_evt_pkg::*;
#(
    parameter int NCTX   = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCTX-1:0]   ctx_irq,
    output logic              irq_summary
);
    localparam int PAD_W = DATA_W - NCTX;

    acc_e            kind;
    logic [NCTX-1:0] rise;
    logic [NCTX-1:0] evt;
    logic [NCTX-1:0] msk;
    logic [NCTX-1:0] wbits;
    logic [NCTX-1:0] evt_set, evt_clr, msk_set, msk_clr;
    logic [NCTX-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    iso_evt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .kind_o (kind)
    );

    iso_evt_edge #(.NCTX(NCTX)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (ctx_irq),
        .rise_o (rise)
    );

    assign wbits = bus_wdata[NCTX-1:0];

    always_comb begin
        evt_set = '0;
        evt_clr = '0;
        msk_set = '0;
        msk_clr = '0;
        if (bus_wr) begin
            unique case (kind)
                ACC_EVT_SET: evt_set = wbits;
                ACC_EVT_CLR: evt_clr = wbits;
                ACC_MSK_SET: msk_set = wbits;
                ACC_MSK_CLR: msk_clr = wbits;
                default:     ;
            endcase
        end
    end

    iso_evt_bits #(.NCTX(NCTX)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .evt_set_i (evt_set),
        .evt_clr_i (evt_clr),
        .msk_set_i (msk_set),
        .msk_clr_i (msk_clr),
        .evt_o     (evt),
        .msk_o     (msk)
    );

    always_comb begin
        unique case (kind)
            ACC_EVT_SET: rd_mux = evt;
            ACC_EVT_CLR: rd_mux = evt & msk;
            ACC_MSK_SET,
            ACC_MSK_CLR: rd_mux = msk;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= {{PAD_W{1'b0}}, rd_mux};
        else             rdata_q <= '0;
    end

    assign bus_rdata   = rdata_q;
    assign irq_summary = |(evt & msk);

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NCTX] == '0);

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/tb_iso_tx_evt_reg.sv
module tb_iso_tx_evt_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ctx_irq = '0;
    logic        irq_summary;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    iso_tx_evt_reg dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctx_irq(ctx_irq), .irq_summary(irq_summary)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R8 reset summary", {31'b0, irq_summary}, 32'h0);
        rd(8'h98, d); check("R8 mask reset", d, 32'h0);
        wr(8'h94, 32'h0000_00FF);
        rd(8'h90, d); check("R4 clear all", d, 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] d;
        wr(8'h90, 32'h0000_0005);
        rd(8'h90, d); check("R3 set", d, 32'h05);
        wr(8'h90, 32'h0);
        rd(8'h90, d); check("R3 zero no effect", d, 32'h05);
        wr(8'h90, 32'hFFFF_FF00);
        rd(8'h90, d); check("R1 upper ignored", d, 32'h05);
        rd(8'h90, d); check("R6 raw read", d, 32'h05);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(8'h94, 32'h0000_0004);
        rd(8'h90, d); check("R4 clear one", d, 32'h01);
        wr(8'h94, 32'h0);
        rd(8'h90, d); check("R4 zero no effect", d, 32'h01);
        wr(8'h94, 32'hFF);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        @(negedge clk); ctx_irq[3] = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h90, d); check("R2 rise sets", d, 32'h08);
        wr(8'h94, 32'h08);
        repeat (2) @(negedge clk);
        rd(8'h90, d); check("R2 level no reset", d, 32'h0);
        ctx_irq[3] = 1'b0;
        @(negedge clk); ctx_irq[3] = 1'b1;
        @(negedge clk); ctx_irq[3] = 1'b0;
        rd(8'h90, d); check("R2 second rise", d, 32'h08);
        wr(8'h94, 32'hFF);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(8'h90, 32'h0F);
        check("R9 masked off", {31'b0, irq_summary}, 32'h0);
        wr(8'h98, 32'h05);
        check("R9 summary on", {31'b0, irq_summary}, 32'h1);
        rd(8'h94, d); check("R5 masked read", d, 32'h05);
        rd(8'h98, d); check("R8 mask read set alias", d, 32'h05);
        rd(8'h9C, d); check("R8 mask read clr alias", d, 32'h05);
        rd(8'h90, d); check("R6 raw ignores mask", d, 32'h0F);
        wr(8'h9C, 32'h05);
        check("R9 summary off", {31'b0, irq_summary}, 32'h0);
        rd(8'h98, d); check("R8 mask cleared", d, 32'h0);
        wr(8'h94, 32'hFF);
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr(8'h90, 32'h04);
        @(negedge clk);
        bus_addr = 8'h94; bus_wdata = 32'h04; bus_wr = 1'b1; ctx_irq[2] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ctx_irq[2] = 1'b0;
        rd(8'h90, d); check("R7 rise beats clear", d, 32'h04);
        wr(8'h94, 32'hFF);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        wr(8'h90, 32'h30);
        rd(8'h90, d);
        @(negedge clk);
        check("R10 idle rdata zero", bus_rdata, 32'h0);
        wr(8'hA0, 32'hFF);
        rd(8'h90, d); check("R11 stray write", d, 32'h30);
        rd(8'hA0, d); check("R11 stray read", d, 32'h0);
        rd(8'h98, d); check("R11 mask untouched", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_clear();
        t_edge();
        t_mask();
        t_race();
        t_misc();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule